// File: doc/BRIEF.md
# SFR Register File with External Bridge

This block implements the special function register space of an 8-bit microcontroller core for the data pointers and the general purpose ports. It holds two 16-bit data pointers and a one-bit register that selects the active pointer. It also holds four 8-bit port output latches, each with its own direction register. The core reaches all of these through a simple synchronous port: a 7-bit address, write data, a write enable and a combinational read data bus. The 7-bit address is the low seven bits of SFR addresses 0x80 to 0xFF.

Each port has separate input, output and direction buses and no tri-state logic. A pad cell outside the block combines them. Any SFR address that the block does not implement is forwarded to an external SFR bus, so user peripherals can add their own registers to the space. The active data pointer is driven out continuously for memory addressing. It can also be incremented by a single-cycle pulse from the core.

Top module: `sfr_ext_bridge`

## Requirements
- R1: While rst_ni is low and after it rises, with no writes yet: both pointers are 0x0000 and the select register is 0. Every port latch reads 0xFF and every direction register reads 0xFF (all bits inputs).
- R2: The select register is at 7-bit address 0x12. A write stores bit 0 of the data. A read returns that bit in bit 0 and returns 0 in bits 7:1.
- R3: A write to address 0x02 (low byte) or 0x03 (high byte) changes only that byte, and only of the pointer chosen by the select register. Reads of 0x02 and 0x03 return the bytes of the selected pointer. The other pointer is unchanged.
- R4: dptr_o always shows the selected pointer. A pulse on dptr_inc_i adds 1 to the selected pointer, modulo 2^16, at the next edge. A write to 0x02 or 0x03 in the same cycle takes priority, and the increment is dropped.
- R5: Port j's latch is at address 16*j (0x00, 0x10, 0x20, 0x30). A write to it appears on port_out_o[8j+7:8j] after the next clock edge.
- R6: Port j's direction register is at address 0x24+j. A write to it appears on port_dir_o[8j+7:8j] after the next edge, and a read of it returns its value.
- R7: A read of port j's latch address returns port_in_i for each bit whose direction bit is 1. For each bit whose direction bit is 0, it returns the latch bit.
- R8: ext_load_o is high exactly in the cycles where sfr_we_i is high and the address is not implemented here. ext_addr_o always equals sfr_addr_i, and ext_wdata_o always equals sfr_wdata_i.
- R9: A read of an address that is not implemented here returns ext_rdata_i in the same cycle.
- R10: A write to an address that is not implemented here leaves every pointer, the select register, every latch and every direction register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sfr_addr_i | input | 7 | SFR address bits 6:0 |
| sfr_wdata_i | input | 8 | Write data |
| sfr_we_i | input | 1 | Write enable |
| sfr_rdata_o | output | 8 | Combinational read data |
| dptr_inc_i | input | 1 | Increment the active pointer |
| dptr_o | output | 16 | Active data pointer |
| dptr_sel_o | output | 1 | Active pointer index |
| port_in_i | input | 32 | Port input buses, port j in bits 8j+7:8j |
| port_out_o | output | 32 | Port output latches |
| port_dir_o | output | 32 | Port directions, 1 = input |
| ext_addr_o | output | 7 | External SFR address |
| ext_wdata_o | output | 8 | External SFR write data |
| ext_rdata_i | input | 8 | External SFR read data |
| ext_load_o | output | 1 | External register load strobe |

## Verification
The assertions assume that the core holds the address and write data stable for the whole cycle in which sfr_we_i is high. They also assume that the register contents change only on write or increment cycles. The pointer increment check assumes that no write happens in the same cycle, because a write could change the select register or a pointer byte. The stimulus applies every input change half a cycle away from the active edge. It mixes increment pulses with and without writes, so both the assumed case and the priority case are covered. Addresses are drawn from a weighted mix of implemented and unimplemented values, so external traffic is interleaved with internal traffic.

// File: rtl/sfr_ext_pkg.sv
package sfr_ext_pkg;
  localparam int unsigned AW         = 7;
  localparam int unsigned DW         = 8;
  localparam int unsigned PTR_W      = 16;
  localparam logic [AW-1:0] A_DPL    = 7'h02;
  localparam logic [AW-1:0] A_DPH    = 7'h03;
  localparam logic [AW-1:0] A_SEL    = 7'h12;
  localparam logic [AW-1:0] A_DIR0   = 7'h24;
  localparam int unsigned PORT_STEP  = 16;
endpackage

// File: rtl/sfr_decode.sv
module sfr_decode
  import sfr_ext_pkg::*;
#(
  parameter int unsigned NPORT = 4
) (
  input  logic [AW-1:0]    addr_i,
  output logic [NPORT-1:0] lat_hit_o,
  output logic [NPORT-1:0] dir_hit_o,
  output logic             dpl_hit_o,
  output logic             dph_hit_o,
  output logic             sel_hit_o,
  output logic             impl_o
);
  for (genvar j = 0; j < NPORT; j++) begin : g_port
    localparam logic [AW-1:0] LAT_A = AW'(j * PORT_STEP);
    localparam logic [AW-1:0] DIR_A = AW'(A_DIR0 + j);
    assign lat_hit_o[j] = (addr_i == LAT_A);
    assign dir_hit_o[j] = (addr_i == DIR_A);
  end

  assign dpl_hit_o = (addr_i == A_DPL);
  assign dph_hit_o = (addr_i == A_DPH);
  assign sel_hit_o = (addr_i == A_SEL);
  assign impl_o    = (|lat_hit_o) | (|dir_hit_o) | dpl_hit_o | dph_hit_o | sel_hit_o;
endmodule

// File: rtl/dptr_bank.sv
module dptr_bank
  import sfr_ext_pkg::*;
#(
  parameter int unsigned NPTR = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DW-1:0]    wdata_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic             wr_sel_i,
  input  logic             inc_i,
  output logic [PTR_W-1:0] dptr_o,
  output logic             sel_o
);
  localparam int unsigned SW = (NPTR > 1) ? $clog2(NPTR) : 1;

  logic [SW-1:0]    sel_q;
  logic [PTR_W-1:0] ptr_q [NPTR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else if (wr_sel_i) sel_q <= SW'(wdata_i[0]);
  end

  for (genvar k = 0; k < NPTR; k++) begin : g_ptr
    logic act;
    assign act = (sel_q == SW'(k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ptr_q[k] <= '0;
      end else if (act && (wr_lo_i || wr_hi_i)) begin
        // byte write wins over increment
        if (wr_lo_i) ptr_q[k][DW-1:0]       <= wdata_i;
        if (wr_hi_i) ptr_q[k][PTR_W-1:DW]   <= wdata_i;
      end else if (act && inc_i) begin
        ptr_q[k] <= ptr_q[k] + PTR_W'(1);
      end
    end
  end

  assign dptr_o = ptr_q[sel_q];
  assign sel_o  = sel_q[0];
endmodule

// File: rtl/port_bank.sv
module port_bank
  import sfr_ext_pkg::*;
#(
  parameter int unsigned NPORT = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DW-1:0]       wdata_i,
  input  logic [NPORT-1:0]    wr_lat_i,
  input  logic [NPORT-1:0]    wr_dir_i,
  input  logic [NPORT*DW-1:0] pin_i,
  output logic [NPORT*DW-1:0] lat_o,
  output logic [NPORT*DW-1:0] dir_o,
  output logic [NPORT*DW-1:0] view_o
);
  for (genvar j = 0; j < NPORT; j++) begin : g_port
    logic [DW-1:0] lat_q, dir_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lat_q <= '1;
        dir_q <= '1;
      end else begin
        if (wr_lat_i[j]) lat_q <= wdata_i;
        if (wr_dir_i[j]) dir_q <= wdata_i;
      end
    end
    assign lat_o[j*DW +: DW]  = lat_q;
    assign dir_o[j*DW +: DW]  = dir_q;
    // dir bit 1 = input: read the pin, else the latch
    assign view_o[j*DW +: DW] = (dir_q & pin_i[j*DW +: DW]) | (~dir_q & lat_q);
  end
endmodule

// File: rtl/sfr_ext_bridge.sv
module sfr_ext_bridge
  import sfr_ext_pkg::*;
#(
  parameter int unsigned NPORT = 4,
  parameter int unsigned NPTR  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [AW-1:0]       sfr_addr_i,
  input  logic [DW-1:0]       sfr_wdata_i,
  input  logic                sfr_we_i,
  output logic [DW-1:0]       sfr_rdata_o,
  input  logic                dptr_inc_i,
  output logic [PTR_W-1:0]    dptr_o,
  output logic                dptr_sel_o,
  input  logic [NPORT*DW-1:0] port_in_i,
  output logic [NPORT*DW-1:0] port_out_o,
  output logic [NPORT*DW-1:0] port_dir_o,
  output logic [AW-1:0]       ext_addr_o,
  output logic [DW-1:0]       ext_wdata_o,
  input  logic [DW-1:0]       ext_rdata_i,
  output logic                ext_load_o
);
  logic [NPORT-1:0]    lat_hit, dir_hit;
  logic                dpl_hit, dph_hit, sel_hit, impl;
  logic [NPORT*DW-1:0] view;

  sfr_decode #(.NPORT(NPORT)) u_dec (
    .addr_i    (sfr_addr_i),
    .lat_hit_o (lat_hit),
    .dir_hit_o (dir_hit),
    .dpl_hit_o (dpl_hit),
    .dph_hit_o (dph_hit),
    .sel_hit_o (sel_hit),
    .impl_o    (impl)
  );

  dptr_bank #(.NPTR(NPTR)) u_dptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wdata_i  (sfr_wdata_i),
    .wr_lo_i  (sfr_we_i & dpl_hit),
    .wr_hi_i  (sfr_we_i & dph_hit),
    .wr_sel_i (sfr_we_i & sel_hit),
    .inc_i    (dptr_inc_i),
    .dptr_o   (dptr_o),
    .sel_o    (dptr_sel_o)
  );

  port_bank #(.NPORT(NPORT)) u_port (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wdata_i  (sfr_wdata_i),
    .wr_lat_i ({NPORT{sfr_we_i}} & lat_hit),
    .wr_dir_i ({NPORT{sfr_we_i}} & dir_hit),
    .pin_i    (port_in_i),
    .lat_o    (port_out_o),
    .dir_o    (port_dir_o),
    .view_o   (view)
  );

  always_comb begin
    sfr_rdata_o = ext_rdata_i;
    if (dpl_hit) sfr_rdata_o = dptr_o[DW-1:0];
    if (dph_hit) sfr_rdata_o = dptr_o[PTR_W-1:DW];
    if (sel_hit) sfr_rdata_o = {{(DW-1){1'b0}}, dptr_sel_o};
    for (int j = 0; j < NPORT; j++) begin
      if (lat_hit[j]) sfr_rdata_o = view[j*DW +: DW];
      if (dir_hit[j]) sfr_rdata_o = port_dir_o[j*DW +: DW];
    end
  end

  assign ext_addr_o  = sfr_addr_i;
  assign ext_wdata_o = sfr_wdata_i;
  assign ext_load_o  = sfr_we_i & ~impl;
endmodule

// File: rtl/sfr_ext_bridge_chk.sv
module sfr_ext_bridge_chk
  import sfr_ext_pkg::*;
#(
  parameter int unsigned NPORT = 4,
  parameter int unsigned NPTR  = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [AW-1:0]       sfr_addr_i,
  input logic [DW-1:0]       sfr_wdata_i,
  input logic                sfr_we_i,
  input logic [DW-1:0]       sfr_rdata_o,
  input logic                dptr_inc_i,
  input logic [PTR_W-1:0]    dptr_o,
  input logic                dptr_sel_o,
  input logic [NPORT*DW-1:0] port_in_i,
  input logic [NPORT*DW-1:0] port_out_o,
  input logic [NPORT*DW-1:0] port_dir_o,
  input logic [AW-1:0]       ext_addr_o,
  input logic [DW-1:0]       ext_wdata_o,
  input logic [DW-1:0]       ext_rdata_i,
  input logic                ext_load_o
);
  p_load_needs_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_load_o |-> sfr_we_i);

  p_load_fields_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_load_o |-> (ext_addr_o == sfr_addr_i && ext_wdata_o == sfr_wdata_i));

  p_sel_upper_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfr_addr_i == A_SEL) |-> (sfr_rdata_o[DW-1:1] == '0 && sfr_rdata_o[0] == dptr_sel_o));

  p_inc_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dptr_inc_i && !sfr_we_i) |=> (dptr_o == $past(dptr_o) + PTR_W'(1)));

  p_ports_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sfr_we_i |=> ($stable(port_out_o) && $stable(port_dir_o)));

  p_sel_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sfr_we_i |=> $stable(dptr_sel_o));
endmodule

bind sfr_ext_bridge sfr_ext_bridge_chk #(.NPORT(NPORT), .NPTR(NPTR)) u_chk (.*);

// File: tb/sfr_ext_bridge_tb.sv
module sfr_ext_bridge_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [6:0]  sfr_addr_i = '0;
  logic [7:0]  sfr_wdata_i = '0;
  logic        sfr_we_i = 1'b0;
  logic [7:0]  sfr_rdata_o;
  logic        dptr_inc_i = 1'b0;
  logic [15:0] dptr_o;
  logic        dptr_sel_o;
  logic [31:0] port_in_i = '0;
  logic [31:0] port_out_o, port_dir_o;
  logic [6:0]  ext_addr_o;
  logic [7:0]  ext_wdata_o;
  logic [7:0]  ext_rdata_i = '0;
  logic        ext_load_o;

  sfr_ext_bridge u_dut (.*);

  always #5 clk_i = ~clk_i;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string force_tag = "";

  // reference state
  int unsigned dp [2];
  int unsigned sel;
  int unsigned lat [4];
  int unsigned dir [4];

  function automatic bit is_impl(input int unsigned a);
    return a == 'h00 || a == 'h10 || a == 'h20 || a == 'h30 || a == 'h02 ||
           a == 'h03 || a == 'h12 || (a >= 'h24 && a <= 'h27);
  endfunction

  task automatic cmp(input string tag, input string what, input int unsigned act, input int unsigned exp);
    string t;
    t = (force_tag != "") ? force_tag : tag;
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
    end
  endtask

  task automatic model_reset();
    dp[0] = 0; dp[1] = 0; sel = 0;
    for (int j = 0; j < 4; j++) begin lat[j] = 'hFF; dir[j] = 'hFF; end
  endtask

  task automatic check_outputs();
    int unsigned a, er, po, pd;
    string rt;
    a = sfr_addr_i;
    er = ext_rdata_i; rt = "R9";
    if (a == 'h02) begin er = dp[sel] & 'hFF; rt = "R3"; end
    else if (a == 'h03) begin er = (dp[sel] >> 8) & 'hFF; rt = "R3"; end
    else if (a == 'h12) begin er = sel; rt = "R2"; end
    else if (a >= 'h24 && a <= 'h27) begin er = dir[a - 'h24]; rt = "R6"; end
    else if (a[3:0] == 0 && a <= 'h30) begin
      int j;
      j = a >> 4;
      er = (dir[j] & ((port_in_i >> (8*j)) & 'hFF)) | (~dir[j] & lat[j] & 'hFF);
      rt = "R7";
    end
    po = 0; pd = 0;
    for (int j = 0; j < 4; j++) begin po |= lat[j] << (8*j); pd |= dir[j] << (8*j); end
    cmp(rt, "rdata", sfr_rdata_o, er);
    cmp("R4", "dptr", dptr_o, dp[sel]);
    cmp("R2", "dptr_sel", dptr_sel_o, sel);
    cmp("R5", "port_out", port_out_o, po);
    cmp("R6", "port_dir", port_dir_o, pd);
    cmp("R8", "ext_load", ext_load_o, (sfr_we_i && !is_impl(a)) ? 1 : 0);
    cmp("R8", "ext_addr", ext_addr_o, a);
    cmp("R8", "ext_wdata", ext_wdata_o, sfr_wdata_i);
  endtask

  // drive at negedge, compare, then advance the model at posedge
  task automatic step(input int unsigned a, input int unsigned wd, input bit we, input bit inc);
    int unsigned s;
    bit wdp;
    @(negedge clk_i);
    sfr_addr_i  = 7'(a);
    sfr_wdata_i = 8'(wd);
    sfr_we_i    = we;
    dptr_inc_i  = inc;
    port_in_i   = $urandom;
    ext_rdata_i = 8'($urandom);
    #1;
    check_outputs();
    @(posedge clk_i);
    if (!rst_ni) begin model_reset(); return; end
    s = sel;
    wdp = we && (a == 'h02 || a == 'h03);
    if (we) begin
      if (a == 'h02) dp[s] = (dp[s] & 'hFF00) | (wd & 'hFF);
      else if (a == 'h03) dp[s] = (dp[s] & 'h00FF) | ((wd & 'hFF) << 8);
      else if (a == 'h12) sel = wd & 1;
      else if (a >= 'h24 && a <= 'h27) dir[a - 'h24] = wd & 'hFF;
      else if (a[3:0] == 0 && a <= 'h30) lat[a >> 4] = wd & 'hFF;
    end
    if (inc && !wdp) dp[s] = (dp[s] + 1) & 'hFFFF;
  endtask

  function automatic int unsigned pick_addr();
    int unsigned r;
    r = $urandom % 16;
    case (r)
      0: return 'h00; 1: return 'h10; 2: return 'h20; 3: return 'h30;
      4: return 'h02; 5: return 'h03; 6: return 'h12;
      7: return 'h24 + ($urandom % 4);
      8: return 'h24 + ($urandom % 4);
      default: return $urandom % 128;
    endcase
  endfunction

  initial begin
    model_reset();
    // R1: reset values, during and just after reset
    force_tag = "R1";
    step('h12, 0, 0, 0);
    step('h00, 0, 0, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    step('h02, 0, 0, 0);
    step('h24, 0, 0, 0);
    step('h30, 0, 0, 0);
    force_tag = "";
    // R2: select write keeps only bit 0
    step('h12, 'hFF, 1, 0);
    step('h12, 0, 0, 0);
    // R3: write pointer 1 bytes, switch to pointer 0
    step('h02, 'hFF, 1, 0);
    step('h03, 'hFF, 1, 0);
    step('h12, 'hFE, 1, 0);
    step('h02, 'h34, 1, 0);
    step('h03, 'h12, 1, 0);
    step('h02, 0, 0, 0);
    // R4: increment wrap on pointer 1, then write priority
    step('h12, 1, 1, 0);
    step('h03, 0, 0, 1);
    step('h03, 0, 0, 0);
    step('h02, 'h55, 1, 1);
    step('h02, 0, 0, 0);
    // R5 / R6 / R7: mixed direction
    step('h10, 'hA5, 1, 0);
    step('h25, 'h0F, 1, 0);
    step('h10, 0, 0, 0);
    step('h25, 0, 0, 0);
    step('h27, 'h00, 1, 0);
    step('h30, 'h3C, 1, 0);
    step('h30, 0, 0, 0);
    // R10 / R8 / R9: external writes leave internal state
    force_tag = "R10";
    for (int i = 0; i < 40; i++) begin
      int unsigned a;
      do a = $urandom % 128; while (is_impl(a));
      step(a, $urandom, 1, 0);
    end
    step('h02, 0, 0, 0);
    step('h30, 0, 0, 0);
    step('h12, 0, 0, 0);
    force_tag = "";
    // random traffic
    for (int i = 0; i < 3000; i++)
      step(pick_addr(), $urandom, ($urandom % 2) == 1, ($urandom % 3) == 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule